// File: doc/BRIEF.md
# Two-Level Debug Breakpoint Trigger Sequencer

This block sequences hardware breakpoint triggers for a processor debug unit. Software loads a 32-bit write-only trigger configuration word. The upper half describes the second trigger level and the lower half describes the first level. External address, program-counter and data comparators each deliver a one-cycle match pulse. The block qualifies these pulses against the sources that each level selects.

Each level has its own enable. When the second-level enable is set, the levels are chained: a first-level hit arms the second level, and only a second-level hit completes the trigger. When it is clear, a first-level hit completes the trigger on its own. On completion the block always pulses a report strobe toward the debug data path. A 2-bit response code can also raise a one-cycle halt request or a one-cycle debug interrupt. The trigger then holds its complete state until software writes the configuration word again, and that write restarts the sequence.

Top module: `dbg_trig_seq`

## Requirements
- R1: After reset, status_o is 0 (idle) and rpt_o, halt_o and irq_o are low. The configuration word resets to all zeros, so no level is enabled.
- R2: A configuration write takes effect at the next clock edge and discards any earlier progress. status_o becomes 1 (level-1 waiting) if bit 13 of the written word is set, and 0 (idle) otherwise.
- R3: Within each 16-bit half, bit 13 is the level enable and bits 2, 1 and 0 select the address, program-counter and data match sources, which arrive on src_hit_i[2], src_hit_i[1] and src_hit_i[0]. A level hits in a cycle when its enable is set and at least one selected source pulses.
- R4: While a level's enable bit is clear, that level never hits. With bit 13 clear, the state stays idle whatever the match inputs do.
- R5: One-level mode (bit 29 clear): a level-1 hit while in state 1 moves status_o to 3 (complete) at the next edge.
- R6: Two-level mode (bit 29 set): a level-1 hit in state 1 moves status_o to 2 (level-2 waiting). A level-2 hit in state 2 then moves it to 3. State 1 never goes straight to 3.
- R7: The response code in bits 31:30 is applied on completion. Code 01 pulses halt_o and code 10 pulses irq_o. Codes 00 and 11 pulse neither of them.
- R8: rpt_o pulses on every completion, whatever the response code.
- R9: rpt_o, halt_o and irq_o are high for exactly the one cycle in which status_o first reads 3. After that, status_o stays 3 and match pulses have no effect until the next configuration write.
- R10: A configuration write in the same cycle as match pulses takes priority. Those pulses are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_we_i | input | 1 | Configuration word write strobe |
| cfg_wdata_i | input | 32 | Configuration word write data |
| src_hit_i | input | 3 | Comparator match pulses: [2] address, [1] program counter, [0] data |
| status_o | output | 2 | Trigger state: 0 idle, 1 level-1 waiting, 2 level-2 waiting, 3 complete |
| rpt_o | output | 1 | Completion report pulse for the debug data path |
| halt_o | output | 1 | Processor halt request pulse |
| irq_o | output | 1 | Debug interrupt request pulse |

## Verification
The bench builds the block with its default parameters: three match sources and a 32-bit configuration word split into two 16-bit halves. With these values, every source-select combination in both halves can be reached, together with all four response codes. Random configuration words are biased toward enabled levels, so chained and unchained completions both occur many times. Directed sequences cover the corner cases: a write in the same cycle as match pulses, matches arriving while the enables are clear, and the reserved response code.

// File: rtl/dbg_trig_pkg.sv
package dbg_trig_pkg;
  localparam int CFG_W  = 32;
  localparam int HALF_W = CFG_W / 2;
  localparam int EN_BIT = 13;
  localparam int CHAIN_BIT = HALF_W + EN_BIT;
  localparam int RESP_MSB = CFG_W - 1;
  localparam int RESP_LSB = CFG_W - 2;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_L1   = 2'd1,
    ST_L2   = 2'd2,
    ST_DONE = 2'd3
  } trig_st_e;

  typedef enum logic [1:0] {
    RESP_RPT  = 2'd0,
    RESP_HALT = 2'd1,
    RESP_IRQ  = 2'd2,
    RESP_RSV  = 2'd3
  } resp_e;
endpackage

// File: rtl/dbg_trig_cond.sv
module dbg_trig_cond
  import dbg_trig_pkg::*;
#(
  parameter int N_SRC = 3
) (
  input  logic [HALF_W-1:0] half_cfg_i,
  input  logic [N_SRC-1:0]  src_hit_i,
  output logic              hit_o
);
  assign hit_o = half_cfg_i[EN_BIT] & (|(half_cfg_i[N_SRC-1:0] & src_hit_i));
endmodule

// File: rtl/dbg_trig_fsm.sv
module dbg_trig_fsm
  import dbg_trig_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     we_i,
  input  logic     new_l1_en_i,
  input  logic     chain_i,
  input  logic     l1_hit_i,
  input  logic     l2_hit_i,
  output trig_st_e st_o,
  output logic     enter_done_o
);
  trig_st_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    if (we_i) begin
      st_d = new_l1_en_i ? ST_L1 : ST_IDLE;
    end else begin
      unique case (st_q)
        ST_L1:   if (l1_hit_i) st_d = chain_i ? ST_L2 : ST_DONE;
        ST_L2:   if (l2_hit_i) st_d = ST_DONE;
        default: st_d = st_q;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= ST_IDLE;
    else         st_q <= st_d;
  end

  assign st_o         = st_q;
  assign enter_done_o = (st_d == ST_DONE) && (st_q != ST_DONE);
endmodule

// File: rtl/dbg_trig_resp.sv
module dbg_trig_resp
  import dbg_trig_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       enter_done_i,
  input  logic [1:0] code_i,
  output logic       rpt_o,
  output logic       halt_o,
  output logic       irq_o
);
  resp_e code;
  assign code = resp_e'(code_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rpt_o  <= 1'b0;
      halt_o <= 1'b0;
      irq_o  <= 1'b0;
    end else begin
      rpt_o  <= enter_done_i;
      halt_o <= enter_done_i && (code == RESP_HALT);
      irq_o  <= enter_done_i && (code == RESP_IRQ);
    end
  end
endmodule

// File: rtl/dbg_trig_seq.sv
module dbg_trig_seq
  import dbg_trig_pkg::*;
#(
  parameter int N_SRC = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_we_i,
  input  logic [CFG_W-1:0] cfg_wdata_i,
  input  logic [N_SRC-1:0] src_hit_i,
  output logic [1:0]       status_o,
  output logic             rpt_o,
  output logic             halt_o,
  output logic             irq_o
);
  logic [CFG_W-1:0] cfg_q;
  logic [1:0]       lvl_hit;
  trig_st_e         st;
  logic             enter_done;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cfg_q <= '0;
    else if (cfg_we_i) cfg_q <= cfg_wdata_i;
  end

  for (genvar g = 0; g < 2; g++) begin : g_lvl
    dbg_trig_cond #(.N_SRC(N_SRC)) u_cond (
      .half_cfg_i (cfg_q[g*HALF_W +: HALF_W]),
      .src_hit_i  (src_hit_i),
      .hit_o      (lvl_hit[g])
    );
  end

  dbg_trig_fsm u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .we_i         (cfg_we_i),
    .new_l1_en_i  (cfg_wdata_i[EN_BIT]),
    .chain_i      (cfg_q[CHAIN_BIT]),
    .l1_hit_i     (lvl_hit[0]),
    .l2_hit_i     (lvl_hit[1]),
    .st_o         (st),
    .enter_done_o (enter_done)
  );

  dbg_trig_resp u_resp (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .enter_done_i (enter_done),
    .code_i       (cfg_q[RESP_MSB:RESP_LSB]),
    .rpt_o        (rpt_o),
    .halt_o       (halt_o),
    .irq_o        (irq_o)
  );

  assign status_o = st;
endmodule

// File: rtl/dbg_trig_seq_chk.sv
module dbg_trig_seq_chk
  import dbg_trig_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             cfg_we_i,
  input logic [CFG_W-1:0] cfg_wdata_i,
  input logic [CFG_W-1:0] cfg_q,
  input logic [1:0]       status_o,
  input logic             rpt_o,
  input logic             halt_o,
  input logic             irq_o
);
  a_r2_write_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_we_i |=> status_o == ($past(cfg_wdata_i[EN_BIT]) ? 2'd1 : 2'd0));

  a_r4_disabled_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cfg_we_i && !cfg_q[EN_BIT] && status_o == 2'd0) |=> status_o == 2'd0);

  a_r6_no_skip: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cfg_we_i && cfg_q[CHAIN_BIT] && status_o == 2'd1) |=> status_o != 2'd3);

  a_r7_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(halt_o && irq_o));

  a_r8_rpt_with_resp: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (halt_o || irq_o) |-> rpt_o);

  a_r9_rpt_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rpt_o |=> !rpt_o);

  a_r9_rpt_in_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rpt_o |-> status_o == 2'd3);

  a_r9_done_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o == 2'd3 && !cfg_we_i) |=> status_o == 2'd3);
endmodule

bind dbg_trig_seq dbg_trig_seq_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cfg_we_i    (cfg_we_i),
  .cfg_wdata_i (cfg_wdata_i),
  .cfg_q       (cfg_q),
  .status_o    (status_o),
  .rpt_o       (rpt_o),
  .halt_o      (halt_o),
  .irq_o       (irq_o)
);

// File: tb/dbg_trig_seq_tb_top.sv
module dbg_trig_seq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int N_RAND = 4000;
  localparam int WDOG = 150000;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cfg_we_i = 1'b0;
  logic [31:0] cfg_wdata_i = '0;
  logic [2:0]  src_hit_i = '0;
  logic [1:0]  status_o;
  logic        rpt_o, halt_o, irq_o;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  logic [31:0] m_cfg = '0;
  logic [1:0]  m_st = 2'd0;
  logic        m_rpt = 0, m_halt = 0, m_irq = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  dbg_trig_seq dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .cfg_we_i(cfg_we_i), .cfg_wdata_i(cfg_wdata_i),
    .src_hit_i(src_hit_i), .status_o(status_o), .rpt_o(rpt_o), .halt_o(halt_o), .irq_o(irq_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [1:0] next_st(input logic [1:0] st, input logic we,
                                         input logic [31:0] wd, input logic [31:0] cfg,
                                         input logic [2:0] src);
    logic h1, h2;
    h1 = cfg[13] && |(cfg[2:0] & src);
    h2 = cfg[29] && |(cfg[18:16] & src);
    if (we) return wd[13] ? 2'd1 : 2'd0;
    if (st == 2'd1 && h1) return cfg[29] ? 2'd2 : 2'd3;
    if (st == 2'd2 && h2) return 2'd3;
    return st;
  endfunction

  task automatic step(input logic we, input logic [31:0] wd, input logic [2:0] src);
    logic [1:0] n;
    logic enter;
    cfg_we_i = we; cfg_wdata_i = wd; src_hit_i = src;
    n = next_st(m_st, we, wd, m_cfg, src);
    enter = (n == 2'd3) && (m_st != 2'd3);
    m_rpt  = enter;
    m_halt = enter && (m_cfg[31:30] == 2'b01);
    m_irq  = enter && (m_cfg[31:30] == 2'b10);
    if (we) m_cfg = wd;
    m_st = n;
    @(negedge clk_i);
    chk("R2 R3 R5 R6 R9 status", {30'd0, status_o}, {30'd0, m_st});
    chk("R8 rpt", {31'd0, rpt_o}, {31'd0, m_rpt});
    chk("R7 halt", {31'd0, halt_o}, {31'd0, m_halt});
    chk("R7 irq", {31'd0, irq_o}, {31'd0, m_irq});
  endtask

  function automatic logic [31:0] mk_cfg(input logic [1:0] code, input logic chain,
                                         input logic [2:0] s2, input logic en1,
                                         input logic [2:0] s1);
    return {code, chain, 10'd0, s2, 2'd0, en1, 10'd0, s1};
  endfunction

  initial begin
    void'($urandom(32'd20240611));
    #(3*CLK_PERIOD);
    @(negedge clk_i);
    chk("R1 status", {30'd0, status_o}, 32'd0);
    chk("R1 pulses", {29'd0, rpt_o, halt_o, irq_o}, 32'd0);
    rst_ni = 1'b1;

    // R1 / R4: reset config has no enables
    step(0, 0, 3'b111); step(0, 0, 3'b111);
    // R4: enables clear, sources selected
    step(1, mk_cfg(2'b01, 0, 3'b111, 0, 3'b111), 3'b000);
    step(0, 0, 3'b111); step(0, 0, 3'b111);
    chk("R4 idle with enables clear", {30'd0, status_o}, 32'd0);
    // R5 one-level, halt
    step(1, mk_cfg(2'b01, 0, 3'b000, 1, 3'b010), 3'b000);
    step(0, 0, 3'b101);
    chk("R3 unselected sources ignored", {30'd0, status_o}, 32'd1);
    step(0, 0, 3'b010);
    chk("R5 one-level complete", {30'd0, status_o}, 32'd3);
    chk("R7 halt code 01", {31'd0, halt_o}, 32'd1);
    step(0, 0, 3'b111);
    chk("R9 single pulse", {29'd0, rpt_o, halt_o, irq_o}, 32'd0);
    chk("R9 hold complete", {30'd0, status_o}, 32'd3);
    // R6 two-level, irq
    step(1, mk_cfg(2'b10, 1, 3'b100, 1, 3'b001), 3'b000);
    step(0, 0, 3'b100);
    chk("R6 level-2 source before arm", {30'd0, status_o}, 32'd1);
    step(0, 0, 3'b001);
    chk("R6 armed", {30'd0, status_o}, 32'd2);
    step(0, 0, 3'b001);
    step(0, 0, 3'b100);
    chk("R7 irq code 10", {31'd0, irq_o}, 32'd1);
    // R7 reserved code 11
    step(1, mk_cfg(2'b11, 0, 3'b000, 1, 3'b111), 3'b000);
    step(0, 0, 3'b001);
    chk("R7 code 11 no halt/irq", {30'd0, halt_o, irq_o}, 32'd0);
    chk("R8 rpt on code 11", {31'd0, rpt_o}, 32'd1);
    // R10: write with matches
    step(1, mk_cfg(2'b01, 0, 3'b000, 1, 3'b111), 3'b111);
    chk("R10 write wins", {30'd0, status_o}, 32'd1);
    // R2: write mid-sequence restarts
    step(1, mk_cfg(2'b00, 1, 3'b111, 1, 3'b111), 3'b000);
    step(0, 0, 3'b010);
    step(1, mk_cfg(2'b00, 0, 3'b000, 0, 3'b000), 3'b000);
    chk("R2 write clears status", {30'd0, status_o}, 32'd0);

    for (int i = 0; i < N_RAND; i++) begin
      logic we;
      logic [31:0] wd;
      we = ($urandom_range(0, 15) == 0);
      wd = $urandom;
      if ($urandom_range(0, 3) != 0) wd[13] = 1'b1;
      step(we, we ? wd : 32'd0, 3'($urandom_range(0, 7) & $urandom_range(0, 7)));
    end

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    for (int c = 0; c < WDOG; c++) @(posedge clk_i);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule